// File: doc/BRIEF.md
# Flash write-protection guard

This block sits in front of an embedded flash controller. It judges every erase or program request against the current protection settings. An accepted request leads to a one-cycle grant pulse towards the controller. A rejected request gives no grant and sets a sticky write-protection error flag. Software clears that flag by writing one to it. The inputs are a command strobe with three request bits (mass erase, sector erase, program), a sector number, a program target address, twelve active-low sector protect bits, sixteen one-time-programmable (OTP) block lock bits, a readout-protection-active bit and an intrusion indication.

The control is a three-state machine. `ST_IDLE` is entered on reset, and the machine returns to it whenever no strobe arrives or the strobe carries no request bit. `ST_GRANT` is entered for one cycle when a strobe is accepted. `ST_DENY` is entered for one cycle when a strobe is rejected. All three states use the same transitions, so strobes on consecutive cycles are each judged in turn: accept moves to `ST_GRANT`, reject moves to `ST_DENY`, and no strobe or an ignored request moves to `ST_IDLE`. The error flag is set on the same edge that enters `ST_DENY`.

Top module: `flash_guard`

## Requirements
- R1: After reset, `grant` and `wp_err` are both 0.
- R2: A strobe that is accepted raises `grant` for exactly the one cycle after the strobe. A rejected strobe gives no grant. Strobes on consecutive cycles are each judged independently.
- R3: A strobe that sets more than one of `req_mass`, `req_sect` and `req_prog` is rejected.
- R4: A sector erase with `sect_num` of 12 or more is rejected.
- R5: A sector erase of sector i is rejected when `wp_n[i]` is 0 and granted when `wp_n[i]` is 1.
- R6: A mass erase is rejected when any bit of `wp_n` is 0 and granted only when all twelve bits are 1.
- R7: When `rdp_on` and `intrusion` are both 1, every erase and every program is rejected. Either signal alone changes nothing.
- R8: A program to user flash (0x0800_0000 to 0x080F_FFFF) is rejected when the target sector's `wp_n` bit is 0. Sectors 0–3 are 16 KiB each from 0x0800_0000, sector 4 is 64 KiB from 0x0801_0000, and sectors 5–11 are 128 KiB each from 0x0802_0000.
- R9: A program to system memory (0x1FFF_0000 to 0x1FFF_77FF), to the reserved region (0x1FFF_7A00 to 0x1FFF_7FFF), to the configuration sector (0x1FFF_C000 to 0x1FFF_C00F) or to any unmapped address is rejected.
- R10: The OTP area spans 0x1FFF_7800 to 0x1FFF_79FF as sixteen 32-byte blocks, and the block index is address bits [8:5]. A program into block k is rejected when `otp_lock[k]` is 1 and granted when it is 0.
- R11: `wp_err` becomes 1 in the cycle after a rejected strobe and holds. `err_clr` = 1 clears it from the next cycle. A rejection that arrives in the same cycle as `err_clr` wins, and the flag stays 1.
- R12: A strobe with none of the three request bits set gives no grant and leaves `wp_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per request |
| req_mass | input | 1 | Mass-erase request bit |
| req_sect | input | 1 | Sector-erase request bit |
| req_prog | input | 1 | Program request bit |
| sect_num | input | 4 | Sector index for sector erase |
| prog_addr | input | 32 | Byte address for program |
| wp_n | input | 12 | Per-sector protect bits, 0 = protected |
| otp_lock | input | 16 | OTP block lock bits, 1 = locked |
| rdp_on | input | 1 | Readout protection active |
| intrusion | input | 1 | Debugger attached or running from RAM |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| grant | output | 1 | One-cycle operation grant |
| wp_err | output | 1 | Sticky write-protection error flag |

## Verification
The error flag has two drivers that can act in the same cycle: a rejected strobe that sets it and a software clear that resets it. The bench provokes the clash by raising `err_clr` in the same cycle as a rejected strobe. It expects the flag to stay 1, then clears it alone and expects 0. It also pairs the clear with an accepted strobe and expects the flag at 0 while the grant pulses. Back-to-back strobes, an accepted one followed by a rejected one, check that a grant and a new error appear on successive cycles.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int SECT_CNT   = 12;
    localparam int SECT_W     = 4;
    localparam int SECT_PAD   = (1 << SECT_W) - SECT_CNT;
    localparam int OTP_BLOCKS = 16;
    localparam int OTP_W      = $clog2(OTP_BLOCKS);
    localparam int ADDR_W     = 32;

    localparam logic [ADDR_W-1:0] USER_FIRST = 32'h0800_0000;
    localparam logic [ADDR_W-1:0] USER_LAST  = 32'h080F_FFFF;
    localparam logic [ADDR_W-1:0] SYS_FIRST  = 32'h1FFF_0000;
    localparam logic [ADDR_W-1:0] SYS_LAST   = 32'h1FFF_77FF;
    localparam logic [ADDR_W-1:0] OTP_FIRST  = 32'h1FFF_7800;
    localparam logic [ADDR_W-1:0] OTP_LAST   = 32'h1FFF_79FF;
    localparam logic [ADDR_W-1:0] RSVD_FIRST = 32'h1FFF_7A00;
    localparam logic [ADDR_W-1:0] RSVD_LAST  = 32'h1FFF_7FFF;
    localparam logic [ADDR_W-1:0] CFG_FIRST  = 32'h1FFF_C000;
    localparam logic [ADDR_W-1:0] CFG_LAST   = 32'h1FFF_C00F;

    typedef enum logic [2:0] {
        RGN_USER,
        RGN_SYS,
        RGN_OTP,
        RGN_RSVD,
        RGN_CFG,
        RGN_NONE
    } region_e;

    typedef enum logic [1:0] {
        VD_IGNORE,
        VD_ALLOW,
        VD_DENY
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT,
        ST_DENY
    } state_e;

endpackage

// File: rtl/flash_guard_decode.sv
module flash_guard_decode
    import flash_guard_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [SECT_W-1:0] user_sect,
    output logic [OTP_W-1:0]  otp_blk
);

    always_comb begin
        if (addr >= USER_FIRST && addr <= USER_LAST)
            region = RGN_USER;
        else if (addr >= OTP_FIRST && addr <= OTP_LAST)
            region = RGN_OTP;
        else if (addr >= RSVD_FIRST && addr <= RSVD_LAST)
            region = RGN_RSVD;
        else if (addr >= SYS_FIRST && addr <= SYS_LAST)
            region = RGN_SYS;
        else if (addr >= CFG_FIRST && addr <= CFG_LAST)
            region = RGN_CFG;
        else
            region = RGN_NONE;
    end

    // Uneven sector layout: four small, one medium, seven large.
    always_comb begin
        if (addr[19:16] == 4'd0)
            user_sect = {2'b00, addr[15:14]};
        else if (addr[19:17] == 3'd0)
            user_sect = 4'd4;
        else
            user_sect = 4'd4 + {1'b0, addr[19:17]};
    end

    assign otp_blk = addr[5 +: OTP_W];

    always_comb begin
        if (region == RGN_USER) begin
            AST_SECT_IN_RANGE: assert (user_sect < SECT_W'(SECT_CNT)); // R8
        end
    end

endmodule

// File: rtl/flash_guard_rules.sv
module flash_guard_rules
    import flash_guard_pkg::*;
(
    input  logic                  req_mass,
    input  logic                  req_sect,
    input  logic                  req_prog,
    input  logic [SECT_W-1:0]     sect_num,
    input  logic [SECT_CNT-1:0]   wp_n,
    input  region_e               region,
    input  logic [SECT_W-1:0]     user_sect,
    input  logic [OTP_W-1:0]      otp_blk,
    input  logic [OTP_BLOCKS-1:0] otp_lock,
    input  logic                  rdp_on,
    input  logic                  intrusion,
    output verdict_e              verdict
);

    logic [(1<<SECT_W)-1:0] open_pad;
    logic [1:0]             req_cnt;
    logic                   intr_block;
    logic                   sect_valid;

    // Padding entries read as protected, so a bad index can never pass.
    assign open_pad   = {{SECT_PAD{1'b0}}, wp_n};
    assign req_cnt    = 2'(req_mass) + 2'(req_sect) + 2'(req_prog);
    assign intr_block = rdp_on & intrusion;
    assign sect_valid = sect_num < SECT_W'(SECT_CNT);

    always_comb begin
        verdict = VD_DENY;
        if (req_cnt == 2'd0)
            verdict = VD_IGNORE;
        else if (intr_block || req_cnt > 2'd1)
            verdict = VD_DENY;
        else if (req_mass)
            verdict = (&wp_n) ? VD_ALLOW : VD_DENY;
        else if (req_sect)
            verdict = (sect_valid && open_pad[sect_num]) ? VD_ALLOW : VD_DENY;
        else begin
            unique case (region)
                RGN_USER: verdict = open_pad[user_sect] ? VD_ALLOW : VD_DENY;
                RGN_OTP:  verdict = otp_lock[otp_blk] ? VD_DENY : VD_ALLOW;
                default:  verdict = VD_DENY;
            endcase
        end
    end

    always_comb begin
        if (req_cnt == 2'd1 && req_mass && !(&wp_n)) begin
            AST_MASS_NEEDS_OPEN: assert (verdict == VD_DENY); // R6
        end
    end

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
    import flash_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  verdict_e verdict,
    input  logic     err_clr,
    output logic     grant,
    output logic     err_flag
);

    state_e state_q, state_d;
    logic   deny_now;

    assign deny_now = cmd_valid && (verdict == VD_DENY);

    // Every state shares the same exits, so consecutive strobes are each judged.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (cmd_valid && verdict == VD_ALLOW)
                    state_d = ST_GRANT;
                else if (deny_now)
                    state_d = ST_DENY;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        grant = (state_q == ST_GRANT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (deny_now)
            err_flag <= 1'b1;
        else if (err_clr)
            err_flag <= 1'b0;
    end

    AST_GRANT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(cmd_valid)); // R2
    AST_DENY_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DENY) |-> err_flag); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_now && err_clr) |=> err_flag); // R11
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !deny_now) |=> !err_flag); // R11

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  req_mass,
    input  logic                  req_sect,
    input  logic                  req_prog,
    input  logic [SECT_W-1:0]     sect_num,
    input  logic [ADDR_W-1:0]     prog_addr,
    input  logic [SECT_CNT-1:0]   wp_n,
    input  logic [OTP_BLOCKS-1:0] otp_lock,
    input  logic                  rdp_on,
    input  logic                  intrusion,
    input  logic                  err_clr,
    output logic                  grant,
    output logic                  wp_err
);

    region_e           region;
    logic [SECT_W-1:0] user_sect;
    logic [OTP_W-1:0]  otp_blk;
    verdict_e          verdict;

    flash_guard_decode i_decode (
        .addr      (prog_addr),
        .region    (region),
        .user_sect (user_sect),
        .otp_blk   (otp_blk)
    );

    flash_guard_rules i_rules (
        .req_mass  (req_mass),
        .req_sect  (req_sect),
        .req_prog  (req_prog),
        .sect_num  (sect_num),
        .wp_n      (wp_n),
        .region    (region),
        .user_sect (user_sect),
        .otp_blk   (otp_blk),
        .otp_lock  (otp_lock),
        .rdp_on    (rdp_on),
        .intrusion (intrusion),
        .verdict   (verdict)
    );

    flash_guard_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .verdict  (verdict),
        .err_clr  (err_clr),
        .grant    (grant),
        .err_flag (wp_err)
    );

    AST_CONFLICT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $countones({req_mass, req_sect, req_prog}) > 1) |=> (!grant && wp_err)); // R3
    AST_MASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && req_mass && !(&wp_n)) |=> !grant); // R6
    AST_INTRUSION_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && rdp_on && intrusion && (req_mass || req_sect || req_prog)) |=> (!grant && wp_err)); // R7
    AST_IGNORE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !req_mass && !req_sect && !req_prog && !err_clr) |=> (!grant && $stable(wp_err))); // R12
    AST_BAD_SECTOR_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && req_sect && !req_mass && !req_prog && sect_num >= 4'd12) |=> !grant); // R4

endmodule

// File: tb/test_flash_guard.sv
module test_flash_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    typedef struct packed {
        logic        mass;
        logic        sect;
        logic        prog;
        logic [3:0]  snum;
        logic [31:0] addr;
        logic [11:0] wpn;
        logic [15:0] lock;
        logic        rdp;
        logic        intr;
        logic        exp_g;
        logic        exp_e;
        logic [4:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,4'd3, 32'h0,          12'hFFF,16'h0000,1'b0,1'b0,1'b1,1'b0,5'd5},  // R5 open sector
        '{1'b0,1'b1,1'b0,4'd3, 32'h0,          12'hFF7,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd5},  // R5 protected
        '{1'b0,1'b1,1'b0,4'd11,32'h0,          12'hFFF,16'h0000,1'b0,1'b0,1'b1,1'b0,5'd4},  // R4 last valid
        '{1'b0,1'b1,1'b0,4'd12,32'h0,          12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd4},  // R4 first invalid
        '{1'b0,1'b1,1'b0,4'd15,32'h0,          12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd4},  // R4
        '{1'b1,1'b0,1'b0,4'd0, 32'h0,          12'hFFF,16'h0000,1'b0,1'b0,1'b1,1'b0,5'd6},  // R6 all open
        '{1'b1,1'b0,1'b0,4'd0, 32'h0,          12'hFFE,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd6},  // R6 sector 0
        '{1'b1,1'b0,1'b0,4'd0, 32'h0,          12'h7FF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd6},  // R6 sector 11
        '{1'b1,1'b1,1'b0,4'd2, 32'h0,          12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd3},  // R3 mass+sector
        '{1'b0,1'b1,1'b1,4'd2, 32'h0800_0000,  12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd3},  // R3 program+sector
        '{1'b0,1'b0,1'b1,4'd0, 32'h0800_0000,  12'hFFF,16'h0000,1'b0,1'b0,1'b1,1'b0,5'd8},  // R8 sector 0 open
        '{1'b0,1'b0,1'b1,4'd0, 32'h0800_FFFC,  12'hFF7,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd8},  // R8 sector 3 end
        '{1'b0,1'b0,1'b1,4'd0, 32'h0801_0000,  12'hFF7,16'h0000,1'b0,1'b0,1'b1,1'b0,5'd8},  // R8 sector 4 start
        '{1'b0,1'b0,1'b1,4'd0, 32'h0801_0000,  12'hFEF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd8},  // R8 sector 4 protected
        '{1'b0,1'b0,1'b1,4'd0, 32'h0802_0000,  12'hFDF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd8},  // R8 sector 5
        '{1'b0,1'b0,1'b1,4'd0, 32'h080F_FFFC,  12'h7FF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd8},  // R8 sector 11
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_0000,  12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd9},  // R9 system memory
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_7A00,  12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd9},  // R9 reserved
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_C000,  12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd9},  // R9 configuration
        '{1'b0,1'b0,1'b1,4'd0, 32'h2000_0000,  12'hFFF,16'h0000,1'b0,1'b0,1'b0,1'b1,5'd9},  // R9 unmapped
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_7800,  12'hFFF,16'h0000,1'b0,1'b0,1'b1,1'b0,5'd10}, // R10 block 0 open
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_7830,  12'hFFF,16'h0002,1'b0,1'b0,1'b0,1'b1,5'd10}, // R10 block 1 locked
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_7830,  12'hFFF,16'h0001,1'b0,1'b0,1'b1,1'b0,5'd10}, // R10 other block locked
        '{1'b0,1'b0,1'b1,4'd0, 32'h1FFF_79E0,  12'hFFF,16'h8000,1'b0,1'b0,1'b0,1'b1,5'd10}, // R10 block 15
        '{1'b0,1'b1,1'b0,4'd2, 32'h0,          12'hFFF,16'h0000,1'b1,1'b1,1'b0,1'b1,5'd7},  // R7 erase blocked
        '{1'b0,1'b0,1'b1,4'd0, 32'h0800_4000,  12'hFFF,16'h0000,1'b1,1'b0,1'b1,1'b0,5'd7},  // R7 rdp alone
        '{1'b0,1'b0,1'b1,4'd0, 32'h0800_4000,  12'hFFF,16'h0000,1'b0,1'b1,1'b1,1'b0,5'd7}   // R7 intrusion alone
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        req_mass = 1'b0, req_sect = 1'b0, req_prog = 1'b0;
    logic [3:0]  sect_num = '0;
    logic [31:0] prog_addr = '0;
    logic [11:0] wp_n = 12'hFFF;
    logic [15:0] otp_lock = '0;
    logic        rdp_on = 1'b0, intrusion = 1'b0, err_clr = 1'b0;
    logic        grant, wp_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard i_flash_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .req_mass(req_mass), .req_sect(req_sect), .req_prog(req_prog),
        .sect_num(sect_num), .prog_addr(prog_addr), .wp_n(wp_n),
        .otp_lock(otp_lock), .rdp_on(rdp_on), .intrusion(intrusion),
        .err_clr(err_clr), .grant(grant), .wp_err(wp_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_mass = v.mass; req_sect = v.sect; req_prog = v.prog;
        sect_num = v.snum; prog_addr = v.addr; wp_n = v.wpn;
        otp_lock = v.lock; rdp_on = v.rdp; intrusion = v.intr;
    endtask

    task automatic idle_inputs();
        cmd_valid = 1'b0; req_mass = 1'b0; req_sect = 1'b0; req_prog = 1'b0;
        rdp_on = 1'b0; intrusion = 1'b0; wp_n = 12'hFFF; otp_lock = '0;
    endtask

    task automatic clear_flag();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    function automatic vec_t mk(input logic m, input logic s, input logic p,
                                input logic [31:0] a);
        vec_t v = '0;
        v.mass = m; v.sect = s; v.prog = p; v.addr = a;
        v.snum = 4'd1; v.wpn = 12'hFFF;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", grant, 1'b0);
        chk("R1 flag in reset", wp_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", grant, 1'b0);
        chk("R1 flag after reset", wp_err, 1'b0);

        for (int i = 0; i < NV; i++) begin
            clear_flag();
            @(negedge clk);
            drive(VECS[i]);
            cmd_valid = 1'b1;
            @(negedge clk);
            idle_inputs();
            chk($sformatf("R%0d vector %0d grant", VECS[i].req, i), grant, VECS[i].exp_g);
            chk($sformatf("R11 vector %0d flag", i), wp_err, VECS[i].exp_e);
            @(negedge clk);
            chk($sformatf("R2 vector %0d grant ends", i), grant, 1'b0);
        end

        // R12: ignored strobe, with the flag clear and with it set
        clear_flag();
        @(negedge clk); drive(mk(1'b0, 1'b0, 1'b0, 32'h0800_0000)); cmd_valid = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R12 no grant", grant, 1'b0);
        chk("R12 flag stays 0", wp_err, 1'b0);
        @(negedge clk); drive(mk(1'b0, 1'b0, 1'b1, 32'h2000_0000)); cmd_valid = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R11 flag set", wp_err, 1'b1);
        @(negedge clk); drive(mk(1'b0, 1'b0, 1'b0, 32'h0)); cmd_valid = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R12 no grant with flag set", grant, 1'b0);
        chk("R12 flag stays 1", wp_err, 1'b1);

        // R11: sticky across an accepted request
        @(negedge clk); drive(mk(1'b0, 1'b0, 1'b1, 32'h0800_0000)); cmd_valid = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R2 grant while flag set", grant, 1'b1);
        chk("R11 flag held", wp_err, 1'b1);

        // R11: set wins over clear in the same cycle
        @(negedge clk); drive(mk(1'b1, 1'b1, 1'b0, 32'h0)); cmd_valid = 1'b1; err_clr = 1'b1;
        @(negedge clk); idle_inputs(); err_clr = 1'b0;
        chk("R11 set beats clear", wp_err, 1'b1);
        chk("R11 no grant on set", grant, 1'b0);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk("R11 clear alone", wp_err, 1'b0);

        // R11: clear alongside an accepted request
        @(negedge clk); drive(mk(1'b0, 1'b0, 1'b1, 32'h0)); cmd_valid = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R11 flag set again", wp_err, 1'b1);
        @(negedge clk); drive(mk(1'b0, 1'b1, 1'b0, 32'h0)); cmd_valid = 1'b1; err_clr = 1'b1;
        @(negedge clk); idle_inputs(); err_clr = 1'b0;
        chk("R11 clear with grant", wp_err, 1'b0);
        chk("R2 grant with clear", grant, 1'b1);

        // R2: back-to-back accepted then rejected strobes
        @(negedge clk); drive(mk(1'b0, 1'b1, 1'b0, 32'h0)); cmd_valid = 1'b1;
        @(negedge clk); drive(mk(1'b0, 1'b0, 1'b1, 32'h1FFF_0000)); cmd_valid = 1'b1;
        chk("R2 first grant", grant, 1'b1);
        chk("R2 flag not yet", wp_err, 1'b0);
        @(negedge clk); idle_inputs();
        chk("R2 second denied", grant, 1'b0);
        chk("R2 second flag", wp_err, 1'b1);

        // R1: reset mid-operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 flag cleared by reset", wp_err, 1'b0);
        chk("R1 grant cleared by reset", grant, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule